// File: doc/BRIEF.md
# Segmented Block-Read Payload Receiver

This block collects the payload of a block read from an SPI slave, after the read command has already been accepted. The payload comes back in packets. The size of a full packet is a power of two set by the caller. Any remainder goes in a shorter final packet. Ahead of every packet the slave may send any number of idle bytes, and then a start header. After every packet it may send a two-byte checksum.

The block asks a byte-wide SPI shifter for one byte at a time and sends a zero filler byte on each request. While it hunts for a header, it throws away the bytes it reads. Payload bytes are passed on as a byte stream with a valid strobe. When checksums are enabled, each packet's checksum is checked on its own. When the whole length has been delivered the block raises `done`. If it cannot continue, it raises one of three error flags instead. Issuing the command and clocking the SPI bus are left to neighbouring logic.

Top module: `seg_pkt_rx`

## Requirements
- R1: A `start` with `total_len` below 5 sets `err_len` on the clock edge that takes `start`. No byte is requested, and neither `done` nor any other flag is set.
- R2: Each byte request is a one-cycle `spi_req` with `spi_tx` equal to 0x00. After a request, no further request is made until `spi_rx_valid` has returned that byte.
- R3: The payload is split into packets of 2^`pkt_log2` bytes. When `total_len` is not a multiple of that size, the final packet holds the remainder. Every payload byte appears once, in order, as a one-cycle pulse on `out_valid` with the byte on `out_byte`.
- R4: Before each packet, received bytes whose upper nibble is not 0xF are discarded. The first byte whose upper nibble is 0xF is the header. Neither the header nor any discarded byte is ever output.
- R5: The header hunt accepts a header on any of the first 101 reads of a packet. If 101 reads in a row give no header, the block sets `err_hunt`, reads no payload and makes no further requests.
- R6: When `crc_en` was high at `start`, two checksum bytes are read after each packet, high byte first. They are compared with a CRC-16 computed over that packet's payload only: polynomial 0x1021, data fed MSB first, register seeded with 0xFFFF at each header.
- R7: If a packet's checksum does not match, the block sets `err_crc` after the second checksum byte and makes no further requests.
- R8: `done` is set only after the last payload byte has been read, or after the last checksum has passed when checksums are enabled. The total number of requests equals the sum of the hunt, payload and checksum bytes. `done` and the error flags are never high together.
- R9: After reset, `busy`, `done`, all error flags, `out_valid` and `spi_req` are low. Flags keep their value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer; taken only when not busy |
| total_len | input | LEN_W | Total payload bytes to receive |
| pkt_log2 | input | 4 | Log2 of the full packet size (values above MAX_LOG2 are limited to it) |
| crc_en | input | 1 | Expect and check a CRC-16 after each packet |
| spi_req | output | 1 | Request one byte exchange from the shifter |
| spi_tx | output | 8 | Filler byte sent on the request |
| spi_rx_valid | input | 1 | Received byte is present |
| spi_rx | input | 8 | Received byte |
| out_valid | output | 1 | Payload byte strobe |
| out_byte | output | 8 | Payload byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completed without error |
| err_len | output | 1 | Length rejected |
| err_hunt | output | 1 | No header within the poll limit |
| err_crc | output | 1 | Packet checksum mismatch |

## Verification
The main flow is tried with lengths that are an exact multiple of the packet size, lengths that leave a short final packet, and a single packet shorter than the packet size. Each of these is run with and without checksums, so that splitting errors and per-packet reseeding errors both show up. The idle gaps before headers range from none to 100 bytes: 100 bytes is the longest gap that still succeeds, and a 101-byte gap must fail the hunt. A corrupted checksum in the middle packet checks that the block stops early and keeps exactly the earlier payload. A length of 4 checks the length boundary.

// File: rtl/segrx_pkg.sv
package segrx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_DATA,
    ST_CRC_HI,
    ST_CRC_LO,
    ST_END
  } seg_state_e;

  localparam logic [15:0] CRC_SEED   = 16'hFFFF;
  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam logic [3:0]  HDR_NIBBLE = 4'hF;

  // One byte through the CRC register, MSB first, one bit at a time.
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ b[i];
      r  = {r[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return r;
  endfunction

endpackage

// File: rtl/segrx_crc16.sv
module segrx_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import segrx_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= CRC_SEED;
    else if (seed) crc <= CRC_SEED;
    else if (upd)  crc <= crc16_byte(crc, din);
  end
endmodule

// File: rtl/segrx_seg_len.sv
module segrx_seg_len #(
  parameter int LEN_W    = 24,
  parameter int MAX_LOG2 = 13
) (
  input  logic [LEN_W-1:0] remaining,
  input  logic [3:0]       log2_sel,
  output logic [LEN_W-1:0] seg_len
);
  logic [3:0]       lg_eff;
  logic [LEN_W-1:0] full_sz;

  always_comb begin
    lg_eff  = (log2_sel > 4'(MAX_LOG2)) ? 4'(MAX_LOG2) : log2_sel;
    full_sz = LEN_W'(1) << lg_eff;
    seg_len = (remaining < full_sz) ? remaining : full_sz;
  end
endmodule

// File: rtl/segrx_byte_link.sv
module segrx_byte_link (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic rx_valid,
  output logic req,
  output logic accept
);
  logic pend;

  assign req    = want && !pend;
  assign accept = rx_valid && pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend <= 1'b0;
    else if (req)    pend <= 1'b1;
    else if (accept) pend <= 1'b0;
  end

  AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req); // R2
endmodule

// File: rtl/seg_pkt_rx.sv
module seg_pkt_rx #(
  parameter int           LEN_W      = 24,
  parameter int           MAX_LOG2   = 13,
  parameter int           HUNT_LIMIT = 101,
  parameter int           LEN_MIN    = 5,
  parameter logic [7:0]   FILLER     = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] total_len,
  input  logic [3:0]       pkt_log2,
  input  logic             crc_en,
  output logic             spi_req,
  output logic [7:0]       spi_tx,
  input  logic             spi_rx_valid,
  input  logic [7:0]       spi_rx,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             busy,
  output logic             done,
  output logic             err_len,
  output logic             err_hunt,
  output logic             err_crc
);
  import segrx_pkg::*;

  localparam int PW = $clog2(HUNT_LIMIT + 1);

  seg_state_e       st;
  logic [LEN_W-1:0] rem;
  logic [LEN_W-1:0] pkt_len;
  logic [LEN_W-1:0] pkt_cnt;
  logic [PW-1:0]    poll_cnt;
  logic [3:0]       lg_q;
  logic             crc_en_q;
  logic [7:0]       crc_hi;

  // Named internal events
  logic             acc;
  logic             hdr_hit;
  logic             hunt_giveup;
  logic             data_byte;
  logic             pkt_end;
  logic             xfer_last;
  logic             crc_match;
  logic             len_bad;
  logic [LEN_W-1:0] next_seg;
  logic [15:0]      crc_val;

  assign busy   = (st == ST_HUNT) || (st == ST_DATA) || (st == ST_CRC_HI) || (st == ST_CRC_LO);
  assign spi_tx = FILLER;

  segrx_byte_link u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .want     (busy),
    .rx_valid (spi_rx_valid),
    .req      (spi_req),
    .accept   (acc)
  );

  segrx_seg_len #(.LEN_W(LEN_W), .MAX_LOG2(MAX_LOG2)) u_len (
    .remaining (rem),
    .log2_sel  (lg_q),
    .seg_len   (next_seg)
  );

  assign hdr_hit     = acc && (st == ST_HUNT) && (spi_rx[7:4] == HDR_NIBBLE);
  assign hunt_giveup = acc && (st == ST_HUNT) && !hdr_hit && (poll_cnt == PW'(HUNT_LIMIT - 1));
  assign data_byte   = acc && (st == ST_DATA);
  assign pkt_end     = data_byte && (pkt_cnt == pkt_len - LEN_W'(1));
  assign xfer_last   = (rem == LEN_W'(1));
  assign crc_match   = ({crc_hi, spi_rx} == crc_val);
  assign len_bad     = total_len < LEN_W'(LEN_MIN);

  segrx_crc16 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .seed  (hdr_hit),
    .upd   (data_byte),
    .din   (spi_rx),
    .crc   (crc_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rem       <= '0;
      pkt_len   <= '0;
      pkt_cnt   <= '0;
      poll_cnt  <= '0;
      lg_q      <= '0;
      crc_en_q  <= 1'b0;
      crc_hi    <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      done      <= 1'b0;
      err_len   <= 1'b0;
      err_hunt  <= 1'b0;
      err_crc   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (st)
        ST_IDLE, ST_END: begin
          if (start) begin
            done     <= 1'b0;
            err_len  <= 1'b0;
            err_hunt <= 1'b0;
            err_crc  <= 1'b0;
            if (len_bad) begin
              err_len <= 1'b1;
              st      <= ST_END;
            end else begin
              rem      <= total_len;
              lg_q     <= pkt_log2;
              crc_en_q <= crc_en;
              poll_cnt <= '0;
              st       <= ST_HUNT;
            end
          end
        end
        ST_HUNT: begin
          if (hdr_hit) begin
            pkt_len <= next_seg;
            pkt_cnt <= '0;
            st      <= ST_DATA;
          end else if (hunt_giveup) begin
            err_hunt <= 1'b1;
            st       <= ST_END;
          end else if (acc) begin
            poll_cnt <= poll_cnt + PW'(1);
          end
        end
        ST_DATA: begin
          if (data_byte) begin
            out_valid <= 1'b1;
            out_byte  <= spi_rx;
            rem       <= rem - LEN_W'(1);
            pkt_cnt   <= pkt_cnt + LEN_W'(1);
            if (pkt_end) begin
              poll_cnt <= '0;
              if (crc_en_q)       st <= ST_CRC_HI;
              else if (xfer_last) begin
                done <= 1'b1;
                st   <= ST_END;
              end else            st <= ST_HUNT;
            end
          end
        end
        ST_CRC_HI: begin
          if (acc) begin
            crc_hi <= spi_rx;
            st     <= ST_CRC_LO;
          end
        end
        ST_CRC_LO: begin
          if (acc) begin
            if (!crc_match) begin
              err_crc <= 1'b1;
              st      <= ST_END;
            end else if (rem == '0) begin
              done <= 1'b1;
              st   <= ST_END;
            end else begin
              st <= ST_HUNT;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && len_bad) |=> (err_len && !busy)); // R1
  AST_OUT_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(st) == ST_DATA)); // R3
  AST_PKT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA) |-> (pkt_cnt < pkt_len)); // R3
  AST_HUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HUNT) |-> (poll_cnt < PW'(HUNT_LIMIT))); // R5
  AST_CRC_ERR_ONLY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_crc) |-> crc_en_q); // R7
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, err_len, err_hunt, err_crc}) <= 1); // R8
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_req); // R8
endmodule

// File: tb/seg_pkt_rx_tb_top.sv
module seg_pkt_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 24;
  localparam int TIMEOUT    = 20000;

  typedef struct packed {
    logic [15:0] len;
    logic [3:0]  lg;
    logic        ce;
    logic [7:0]  gap;
    logic [7:0]  seed;
  } vec_t;

  // len, log2 size, crc enable, idle bytes before each header, data seed
  localparam vec_t VEC [6] = '{
    '{16'd10, 4'd2, 1'b0, 8'd0,   8'd1},
    '{16'd10, 4'd2, 1'b1, 8'd1,   8'd2},
    '{16'd16, 4'd3, 1'b1, 8'd3,   8'd3},
    '{16'd5,  4'd3, 1'b1, 8'd0,   8'd4},
    '{16'd33, 4'd4, 1'b0, 8'd2,   8'd5},
    '{16'd20, 4'd5, 1'b1, 8'd100, 8'd6}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [LEN_W-1:0] total_len = '0;
  logic [3:0]       pkt_log2 = '0;
  logic             crc_en = 1'b0;
  logic             spi_req;
  logic [7:0]       spi_tx;
  logic             spi_rx_valid = 1'b0;
  logic [7:0]       spi_rx = '0;
  logic             out_valid;
  logic [7:0]       out_byte;
  logic             busy, done, err_len, err_hunt, err_crc;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  int filler_bad = 0;
  int overlap_bad = 0;
  int dly = 0;
  int exp_reads = 0;
  logic [7:0] stim_q [$];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_pkt_rx #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .total_len(total_len),
    .pkt_log2(pkt_log2), .crc_en(crc_en), .spi_req(spi_req), .spi_tx(spi_tx),
    .spi_rx_valid(spi_rx_valid), .spi_rx(spi_rx), .out_valid(out_valid),
    .out_byte(out_byte), .busy(busy), .done(done), .err_len(err_len),
    .err_hunt(err_hunt), .err_crc(err_crc)
  );

  // Shifter model and output capture, all on the falling edge
  always @(negedge clk) begin
    spi_rx_valid = 1'b0;
    if (out_valid) got_q.push_back(out_byte);
    if (dly > 0) begin
      dly--;
      if (dly == 0) begin
        spi_rx_valid = 1'b1;
        spi_rx = (stim_q.size() > 0) ? stim_q.pop_front() : 8'h00;
      end
    end
    if (spi_req) begin
      req_cnt++;
      if (spi_tx != 8'h00) filler_bad++;
      if (dly > 0) overlap_bad++;
      dly = 2;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  // Build the slave's byte stream and the expected payload
  task automatic build(input int len, input int lg, input bit ce, input int gap,
                       input int seed, input int bad_pkt);
    int done_b = 0;
    int pk = 0;
    stim_q.delete(); exp_q.delete(); got_q.delete();
    exp_reads = 0;
    while (done_b < len) begin
      int n = ((len - done_b) < (1 << lg)) ? (len - done_b) : (1 << lg);
      logic [15:0] c = 16'hFFFF;
      for (int g = 0; g < gap; g++) stim_q.push_back((g % 2 == 0) ? 8'h00 : 8'hE7);
      stim_q.push_back(8'hF0 | 8'(pk));
      exp_reads += gap + 1 + n + (ce ? 2 : 0);
      for (int i = 0; i < n; i++) begin
        logic [7:0] b = 8'((done_b + i) * 37 + seed * 11 + 5);
        stim_q.push_back(b);
        exp_q.push_back(b);
        c = ref_crc(c, b);
      end
      if (ce) begin
        stim_q.push_back(c[15:8]);
        stim_q.push_back((pk == bad_pkt) ? (c[7:0] ^ 8'h01) : c[7:0]);
      end
      done_b += n;
      pk++;
    end
  endtask

  task automatic run(input int len, input int lg, input bit ce);
    int t = 0;
    req_cnt = 0;
    @(negedge clk);
    total_len = LEN_W'(len); pkt_log2 = 4'(lg); crc_en = ce; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!(done || err_len || err_hunt || err_crc) && t < TIMEOUT) begin
      @(negedge clk);
      t++;
    end
    chk(t < TIMEOUT, "R8", "transfer finished", t, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_payload(input string tag);
    bit same = (got_q.size() == exp_q.size());
    if (same) foreach (exp_q[i]) if (got_q[i] != exp_q[i]) same = 0;
    chk(same, tag, "payload bytes (count)", got_q.size(), exp_q.size());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!busy && !done && !err_len && !err_hunt && !err_crc && !out_valid && !spi_req,
        "R9", "outputs low in reset", {busy, done, err_len, err_hunt, err_crc, out_valid, spi_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !spi_req, "R9", "idle after reset", {busy, done, spi_req}, 0);

    // Table of good transfers: R3 R4 R6 R8
    foreach (VEC[v]) begin
      build(int'(VEC[v].len), int'(VEC[v].lg), VEC[v].ce, int'(VEC[v].gap), int'(VEC[v].seed), -1);
      run(int'(VEC[v].len), int'(VEC[v].lg), VEC[v].ce);
      chk(done && !err_hunt && !err_crc && !err_len, "R8", "done without error", done, 1);
      cmp_payload(VEC[v].ce ? "R6" : "R3");
      chk(req_cnt == exp_reads, "R4", "byte reads", req_cnt, exp_reads);
    end
    chk(done, "R9", "done held while idle", done, 1);

    // R1: length 4 rejected, no reads
    build(4, 2, 1'b0, 0, 7, -1);
    req_cnt = 0;
    @(negedge clk);
    total_len = 4; pkt_log2 = 2; crc_en = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err_len && !done, "R1", "err_len after start", err_len, 1);
    repeat (10) @(negedge clk);
    chk(req_cnt == 0, "R1", "no reads for short length", req_cnt, 0);

    // R5: 101 idle bytes abort the hunt
    build(10, 2, 1'b0, 101, 8, -1);
    run(10, 2, 1'b0);
    chk(err_hunt && !done, "R5", "err_hunt", err_hunt, 1);
    chk(got_q.size() == 0, "R5", "no payload output", got_q.size(), 0);
    chk(req_cnt == 101, "R5", "reads before giving up", req_cnt, 101);

    // R7: bad checksum on the second packet
    build(10, 2, 1'b1, 0, 9, 1);
    run(10, 2, 1'b1);
    chk(err_crc && !done, "R7", "err_crc", err_crc, 1);
    while (exp_q.size() > 8) exp_q.pop_back();
    cmp_payload("R7");
    chk(req_cnt == 14, "R7", "reads up to failing checksum", req_cnt, 14);

    // R2: filler and one request in flight over the whole run
    chk(filler_bad == 0, "R2", "non-zero filler bytes", filler_bad, 0);
    chk(overlap_bad == 0, "R2", "overlapping requests", overlap_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule